// File: doc/BRIEF.md
# Interrupt Steering Router

This block connects a group of level-style interrupt sources to a bank of legacy interrupt request lines that feed a classic interrupt controller. When a source raises its request, the router notes the source's number in a small first-in first-out queue. It then picks a legacy line that is both assigned to steering and not claimed by anyone else, and raises that line. A single shared handler reads the head of the queue to learn which source it is serving. It writes an acknowledge to retire that entry and release the line.

Each legacy line has a configuration bit that assigns it either to steering or to an on-board legacy device. Lines assigned to a legacy device carry that device's signal straight through, and the router never drives them. A separate per-line in-use input marks steering-owned lines that another agent currently holds, so the router skips them.

Top module: `irq_steer_router`

## Requirements
- R1: A rising edge on source input i (a 0-to-1 change between consecutive clock edges) enqueues the ID i at that clock edge. After that edge `fifoEmpty` is 0 and `headId` shows the oldest queued ID. Entries leave in arrival order.
- R2: Several IDs can be pending at once, up to the queue depth. When several sources rise in the same cycle, one ID is queued per clock edge, in ascending source index order, and none is lost.
- R3: A source whose ID is already waiting is not queued a second time. A source held high makes no further entries.
- R4: A line is free when `pciOwned` is 1 and `lineInUse` is 0 for it. When nothing is steered and the queue is not empty, the lowest-numbered free line is chosen at the next clock edge. Only that line is driven, and it stays fixed while the assignment lasts.
- R5: If no line is free, no line is driven and the queue keeps its entries. Steering begins at the first edge after a line becomes free.
- R6: A line with `pciOwned` at 0 shows `legacyIrq` for that line at once, and the router never drives it.
- R7: A one-cycle `ackWr` pops the head ID and drops the steered line at that edge. An `ackWr` while the queue is empty has no effect.
- R8: If entries remain after an acknowledge, every steering-owned line stays low for one cycle. The lowest free line is then raised again at the next edge.
- R9: If the steered line loses ownership or is marked in use, the assignment is dropped at the next edge and re-chosen at the edge after that.
- R10: `steerValid` is 1 exactly when a line is steered, and `steerLine` gives that line's index. A source edge at edge k is queued at edge k and steered at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIrq | input | NUM_SRC | Interrupt request levels of the sources |
| legacyIrq | input | NUM_LINES | On-board legacy device requests, one per line |
| pciOwned | input | NUM_LINES | 1 = line assigned to steering, 0 = legacy device |
| lineInUse | input | NUM_LINES | 1 = steering-owned line currently claimed elsewhere |
| ackWr | input | 1 | Acknowledge strobe from software: pop head, release line |
| irqOut | output | NUM_LINES | Lines toward the interrupt controller |
| headId | output | SRC_W | ID of the oldest pending source |
| fifoEmpty | output | 1 | No source pending |
| steerValid | output | 1 | A line is currently steered |
| steerLine | output | LINE_W | Index of the steered line |

## Verification
The bench sweeps every source against a set of ownership and in-use masks. It checks that the chosen line is the lowest free one, and that a design searching from the top or ignoring `lineInUse` would light the wrong bit. It raises all sources at once to catch a queue that drops simultaneous edges or orders them wrongly. It re-raises a source that is already queued to catch double entries. It revokes and restores lines mid-assignment. A router that kept driving a revoked line, skipped the one-cycle gap after an acknowledge, or popped on an acknowledge with an empty queue would show a wrong `irqOut` or status value in the cycle sampled.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

  // Strobes from the steering control to the source datapath.
  typedef struct packed {
    logic pop;   // retire the head ID this cycle
  } steerStrobe_t;

endpackage

// File: rtl/irq_steer_datapath.sv
module irq_steer_datapath
  import irq_steer_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int FIFO_DEPTH = 8,
  localparam int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int PTR_W     = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  steerStrobe_t       strobe,
  output logic [SRC_W-1:0]   headId,
  output logic               fifoEmpty
);

  logic [NUM_SRC-1:0] srcPrev;
  logic [NUM_SRC-1:0] reqMask;     // captured edges not yet in the queue
  logic [NUM_SRC-1:0] queuedMask;  // IDs currently in the queue
  logic [NUM_SRC-1:0] riseVec;
  logic [NUM_SRC-1:0] candVec;
  logic [NUM_SRC-1:0] pushMask;
  logic [NUM_SRC-1:0] popMask;
  logic [SRC_W-1:0]   pushId;
  logic               doPush;
  logic               fifoFull;

  logic [SRC_W-1:0]   mem [FIFO_DEPTH];
  logic [PTR_W-1:0]   wrPtr;
  logic [PTR_W-1:0]   rdPtr;
  logic [CNT_W-1:0]   count;

  assign riseVec   = srcIrq & ~srcPrev;
  assign candVec   = reqMask | (riseVec & ~queuedMask);
  assign fifoFull  = (count == CNT_W'(FIFO_DEPTH));
  assign fifoEmpty = (count == '0);
  assign doPush    = (|candVec) && !fifoFull;
  assign headId    = mem[rdPtr];

  // Lowest-indexed candidate wins the single push slot of this cycle.
  always_comb begin
    pushId = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (candVec[i]) pushId = SRC_W'(i);
    end
  end

  assign pushMask = doPush ? (NUM_SRC'(1) << pushId) : '0;
  assign popMask  = strobe.pop ? (NUM_SRC'(1) << headId) : '0;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPrev    <= '0;
      reqMask    <= '0;
      queuedMask <= '0;
      wrPtr      <= '0;
      rdPtr      <= '0;
      count      <= '0;
    end else begin
      srcPrev    <= srcIrq;
      reqMask    <= candVec & ~pushMask;
      queuedMask <= (queuedMask | pushMask) & ~popMask;
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop) rdPtr <= nextPtr(rdPtr);
      case ({doPush, strobe.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushId;
  end

endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irq_steer_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ackWr,
  input  logic                 fifoEmpty,
  input  logic [NUM_LINES-1:0] pciOwned,
  input  logic [NUM_LINES-1:0] lineInUse,
  output steerStrobe_t         strobe,
  output logic                 steerValid,
  output logic [LINE_W-1:0]    steerLine
);

  logic [NUM_LINES-1:0] freeMask;
  logic [LINE_W-1:0]    lowFree;
  logic                 anyFree;

  assign freeMask   = pciOwned & ~lineInUse;
  assign anyFree    = |freeMask;
  assign strobe.pop = ackWr && !fifoEmpty;

  always_comb begin
    lowFree = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (freeMask[i]) lowFree = LINE_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      steerValid <= 1'b0;
      steerLine  <= '0;
    end else if (strobe.pop) begin
      steerValid <= 1'b0;                 // release, leave one idle cycle
    end else if (steerValid && !freeMask[steerLine]) begin
      steerValid <= 1'b0;                 // line revoked or claimed
    end else if (!steerValid && !fifoEmpty && anyFree) begin
      steerValid <= 1'b1;
      steerLine  <= lowFree;
    end
  end

endmodule

// File: rtl/irq_steer_linemux.sv
module irq_steer_linemux #(
  parameter int NUM_LINES = 16,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] legacyIrq,
  input  logic [NUM_LINES-1:0] pciOwned,
  input  logic                 steerValid,
  input  logic [LINE_W-1:0]    steerLine,
  output logic [NUM_LINES-1:0] irqOut
);

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic steerHit;
    assign steerHit  = steerValid && (steerLine == LINE_W'(g));
    assign irqOut[g] = pciOwned[g] ? steerHit : legacyIrq[g];
  end

endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
  import irq_steer_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int NUM_LINES  = 16,
  parameter int FIFO_DEPTH = 8,
  localparam int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   srcIrq,
  input  logic [NUM_LINES-1:0] legacyIrq,
  input  logic [NUM_LINES-1:0] pciOwned,
  input  logic [NUM_LINES-1:0] lineInUse,
  input  logic                 ackWr,
  output logic [NUM_LINES-1:0] irqOut,
  output logic [SRC_W-1:0]     headId,
  output logic                 fifoEmpty,
  output logic                 steerValid,
  output logic [LINE_W-1:0]    steerLine
);

  steerStrobe_t strobe;

  irq_steer_datapath #(.NUM_SRC(NUM_SRC), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .strobe(strobe),
    .headId(headId), .fifoEmpty(fifoEmpty)
  );

  irq_steer_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ackWr(ackWr), .fifoEmpty(fifoEmpty),
    .pciOwned(pciOwned), .lineInUse(lineInUse), .strobe(strobe),
    .steerValid(steerValid), .steerLine(steerLine)
  );

  irq_steer_linemux #(.NUM_LINES(NUM_LINES)) u_mux (
    .legacyIrq(legacyIrq), .pciOwned(pciOwned), .steerValid(steerValid),
    .steerLine(steerLine), .irqOut(irqOut)
  );

endmodule

// File: rtl/irq_steer_checker.sv
module irq_steer_checker #(
  parameter int NUM_LINES = 16,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 ackWr,
  input logic [NUM_LINES-1:0] pciOwned,
  input logic [NUM_LINES-1:0] lineInUse,
  input logic [NUM_LINES-1:0] irqOut,
  input logic                 fifoEmpty,
  input logic                 steerValid,
  input logic [LINE_W-1:0]    steerLine
);

  logic [NUM_LINES-1:0] ownedQ;
  logic [NUM_LINES-1:0] inUseQ;
  logic [NUM_LINES-1:0] belowMask;

  always_ff @(posedge clk) begin
    ownedQ <= pciOwned;
    inUseQ <= lineInUse;
  end

  assign belowMask = (NUM_LINES'(1) << steerLine) - NUM_LINES'(1);

  // R4: at most one steering-owned line is high
  assert_single_line_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqOut & pciOwned));

  // R4: a new assignment lands on a line that was free, with no lower free line
  assert_lowest_free_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(steerValid) |-> (ownedQ[steerLine] && !inUseQ[steerLine]
                           && ((ownedQ & ~inUseQ & belowMask) == '0)));

  // R4: line index holds while the assignment lasts
  assert_line_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (steerValid && $past(steerValid)) |-> $stable(steerLine));

  // R5: nothing pending means no steering-owned line is raised
  assert_empty_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |-> ((irqOut & pciOwned) == '0));

  // R7: an accepted acknowledge drops the steered line
  assert_ack_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ackWr && !fifoEmpty) |=> !steerValid);

  // R9: a revoked or claimed line is released at the next edge
  assert_revoke_R9: assert property (@(posedge clk) disable iff (!rstN)
    (steerValid && (!pciOwned[steerLine] || lineInUse[steerLine])) |=> !steerValid);

endmodule

bind irq_steer_router irq_steer_checker #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rstN(rstN), .ackWr(ackWr), .pciOwned(pciOwned),
  .lineInUse(lineInUse), .irqOut(irqOut), .fifoEmpty(fifoEmpty),
  .steerValid(steerValid), .steerLine(steerLine)
);

// File: tb/sim_irq_steer_router.sv
module sim_irq_steer_router;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int NL = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NS-1:0] srcIrq;
  logic [NL-1:0] legacyIrq, pciOwned, lineInUse, irqOut;
  logic          ackWr, fifoEmpty, steerValid;
  logic [2:0]    headId;
  logic [3:0]    steerLine;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_steer_router u0 (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .legacyIrq(legacyIrq),
    .pciOwned(pciOwned), .lineInUse(lineInUse), .ackWr(ackWr),
    .irqOut(irqOut), .headId(headId), .fifoEmpty(fifoEmpty),
    .steerValid(steerValid), .steerLine(steerLine)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ack();
    ackWr = 1'b1;
    tick();
    ackWr = 1'b0;
    #1;
  endtask

  function automatic logic [NL-1:0] passVal();
    return legacyIrq & ~pciOwned;
  endfunction

  function automatic int lowest(input logic [NL-1:0] v);
    for (int i = 0; i < NL; i++) if (v[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; srcIrq = '0; legacyIrq = 16'h00F3; pciOwned = '0;
    lineInUse = '0; ackWr = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    #1;
    // Reset state, full passthrough (R6, R10)
    chk("R10 reset fifoEmpty", 32'(fifoEmpty), 32'd1);
    chk("R10 reset steerValid", 32'(steerValid), 32'd0);
    chk("R6 reset passthrough", 32'(irqOut), 32'h00F3);

    // R6: ownership mux sweep with nothing steered
    for (int p = 0; p < 16; p++) begin
      pciOwned  = 16'(16'h1111 << (p % 4)) ^ 16'(p * 16'h0909);
      legacyIrq = 16'(~(p * 16'h1357));
      #1;
      chk("R6 legacy passthrough", 32'(irqOut), 32'(passVal()));
    end

    // R1 R4 R5 R10: each source against several masks
    for (int s = 0; s < NS; s++) begin
      for (int m = 0; m < 4; m++) begin
        logic [NL-1:0] freeV;
        int lo;
        legacyIrq = 16'hA55A;
        pciOwned  = 16'((16'h9A5C >> m) ^ (16'(s) * 16'h0111));
        lineInUse = (m == 3) ? pciOwned : (pciOwned & 16'(16'h0F0F << s));
        freeV = pciOwned & ~lineInUse;
        lo = lowest(freeV);
        srcIrq = NS'(1) << s;
        tick();
        chk("R1 queued after edge", 32'(fifoEmpty), 32'd0);
        chk("R1 headId", 32'(headId), 32'(s));
        chk("R10 not yet steered", 32'(steerValid), 32'd0);
        srcIrq = '0;
        tick();
        if (lo >= 0) begin
          chk("R4 lowest free line", 32'(irqOut), 32'(passVal() | (NL'(1) << lo)));
          chk("R10 steerLine", 32'(steerLine), 32'(lo));
        end else begin
          chk("R5 no free line quiet", 32'(irqOut), 32'(passVal()));
          chk("R5 still pending", 32'(fifoEmpty), 32'd0);
        end
        ack();
        chk("R7 popped", 32'(fifoEmpty), 32'd1);
        chk("R7 line dropped", 32'(irqOut), 32'(passVal()));
      end
    end

    // R2 R8: all sources at once, ascending order, one-cycle gap
    legacyIrq = '0; pciOwned = 16'h0F00; lineInUse = '0;
    srcIrq = '1;
    repeat (10) tick();
    for (int j = 0; j < NS; j++) begin
      chk("R2 ascending order", 32'(headId), 32'(j));
      chk("R2 line steered", 32'(irqOut), 32'h0100);
      ack();
      chk("R8 gap after ack", 32'(irqOut), 32'h0000);
      tick();
      chk("R8 re-steer when pending", 32'(irqOut), (j < NS - 1) ? 32'h0100 : 32'h0);
    end
    chk("R3 held level no requeue", 32'(fifoEmpty), 32'd1);
    srcIrq = '0;
    tick();

    // R1: arrival order across cycles
    srcIrq[6] = 1'b1; tick();
    srcIrq[2] = 1'b1; tick();
    srcIrq[4] = 1'b1; tick();
    srcIrq = '0; tick();
    chk("R1 order first", 32'(headId), 32'd6);
    ack();
    chk("R1 order second", 32'(headId), 32'd2);
    ack();
    chk("R1 order third", 32'(headId), 32'd4);
    ack();
    chk("R1 drained", 32'(fifoEmpty), 32'd1);

    // R3: re-raise while queued
    pciOwned = 16'h0010;
    srcIrq[3] = 1'b1; tick();
    srcIrq[3] = 1'b0; tick();
    srcIrq[3] = 1'b1; tick();
    srcIrq[3] = 1'b0; tick();
    chk("R3 head is 3", 32'(headId), 32'd3);
    ack();
    chk("R3 no duplicate", 32'(fifoEmpty), 32'd1);

    // R7: ack on empty is ignored
    legacyIrq = 16'h0003; pciOwned = 16'h00F0;
    ack();
    chk("R7 empty ack fifo", 32'(fifoEmpty), 32'd1);
    chk("R7 empty ack lines", 32'(irqOut), 32'h0003);
    tick();
    chk("R7 empty ack no steer", 32'(steerValid), 32'd0);

    // R9 R5 R6: revoke and restore mid-assignment
    legacyIrq = 16'h0004; pciOwned = 16'h0006; lineInUse = '0;
    srcIrq[5] = 1'b1; tick();
    srcIrq[5] = 1'b0; tick();
    chk("R4 steered to line 1", 32'(irqOut), 32'h0002);
    lineInUse = 16'h0002;
    tick();
    chk("R9 released on in-use", 32'(steerValid), 32'd0);
    tick();
    chk("R9 moved to line 2", 32'(irqOut), 32'h0004);
    chk("R9 steerLine 2", 32'(steerLine), 32'd2);
    legacyIrq = 16'h0000; pciOwned = 16'h0002;
    #1;
    chk("R6 revoked line shows legacy", 32'(irqOut), 32'h0000);
    tick();
    chk("R9 released on revoke", 32'(steerValid), 32'd0);
    tick();
    chk("R5 none free, pending", 32'({fifoEmpty, steerValid}), 32'b00);
    lineInUse = '0;
    tick();
    chk("R5 steer once freed", 32'(irqOut), 32'h0002);
    ack();
    chk("R7 final drain", 32'(fifoEmpty), 32'd1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule